// File: doc/BRIEF.md
# SDR SDRAM Access Controller

This block sits between a simple request port and a four-bank, 32-bit single-data-rate SDRAM. It turns each accepted request into one activate command followed by one column command with auto-precharge. It also runs the power-up sequence, keeps refresh on schedule and returns read data after the programmed CAS latency. The flat request address is split into bank, row and column. Every access is a single beat with auto-precharge, so no row stays open between requests.

The request side is valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Address, data, byte enables and direction must hold steady while `req_valid` is high and `req_ready` is low. `req_ready` stays low during power-up, while an access is in progress and while a refresh is owed. The read response has no ready input, because the memory cannot be stalled. `rsp_valid` is a single-cycle strobe, and the consumer must take `rsp_data` in that cycle.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is held and afterwards, clock enable is high. No command other than NOP leaves the block during reset. `req_ready` stays low until initialisation ends, and the first command comes no earlier than INIT_CYCLES clocks after reset is released.
- R2: Commands on (cs_n, ras_n, cas_n, we_n) use these encodings: MRS=0000, REF=0001, PRE=0010, ACT=0011, WR=0100, RD=0101, NOP=0111. Power-up issues, in order, precharge with address bit 10 high, REF, REF and MRS. The spacing after each is at least T_RP, T_RFC, T_RFC and T_MRD clocks respectively.
- R3: The MRS command carries bank 0. Address bits 2:0 are 000 (burst of one), bit 3 is 0 (sequential), bits 6:4 hold CAS_LAT, and all other bits are 0.
- R4: For a request address A, the activate carries bank A[20:19] and row A[18:8]. The following column command carries the same bank and column A[7:0], and it is WR for a write and RD for a read.
- R5: A column command comes exactly T_RCD clocks after its activate, with address bit 10 set (auto-precharge).
- R6: After a WR no command is issued for at least T_WR+T_RP clocks. After an RD the gap is at least CAS_LAT+T_RP clocks.
- R7: For every RD that appears on the pins, `rsp_valid` is high for exactly one cycle, CAS_LAT+1 clocks later. `rsp_data` then holds the DQ input value from the cycle before. `rsp_valid` is never high at any other time.
- R8: The data bus is driven only in the cycle of a WR. In that cycle `sd_dq_out` equals the request data and `sd_dqm` is the inverse of the byte enables (bit n masks byte n). DQM is 0 on an RD.
- R9: Once initialised, refreshes are issued at intervals of no more than REFRESH_CYCLES plus one access length. A refresh that is owed is served before any waiting request.
- R10: Only an accepted request produces an activate. `req_ready` is low in the cycle after an acceptance. With no request pending, only REF and NOP appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Flat address {bank, row, column} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write |
| rsp_valid | output | 1 | Read data strobe |
| rsp_data | output | 32 | Read data |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | 2 | SDRAM bank select |
| sd_addr | output | 11 | SDRAM multiplexed address |
| sd_dqm | output | 4 | SDRAM byte masks |
| sd_dq_out | output | 32 | Data toward SDRAM |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 32 | Data from SDRAM |

## Verification
A wrong state register or a miscounted wait shows up on the command pins. The bench sees a command too early, in the wrong order or missing, and its spacing check flags this on the next non-NOP command. An error in the read-latency pipe shows within CAS_LAT+2 cycles: the response strobe is missing or lands one cycle off, or it captures the wrong DQ value. An error in the address split or byte masking shows as a bank, row or column mismatch on the activate or column command. Masking faults also surface later as wrong data read back from the memory model. A stuck refresh flag shows as a refresh gap beyond the allowed bound, or as ready staying low.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_RF1,
    ST_RF2,
    ST_MODE,
    ST_IDLE,
    ST_COL
  } ctrl_state_e;
endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 1953,
  localparam int CNT_W = $clog2(INTERVAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pend
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(INTERVAL - 1);
      pend  <= 1'b0;
    end else begin
      if (ack) pend <= 1'b0;
      if (!en) begin
        cnt_q <= CNT_W'(INTERVAL - 1);
      end else if (cnt_q == '0) begin
        cnt_q <= CNT_W'(INTERVAL - 1);
        pend  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R9: an owed refresh is never dropped before it is served
  a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !ack |=> pend);
  // R9: the controller only acknowledges a refresh that is owed
  a_r9_ack_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DATA_W  = 32,
  parameter int CAS_LAT = 3,
  localparam int DEPTH  = CAS_LAT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [DEPTH-1:0] flight_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flight_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      flight_q  <= {flight_q[DEPTH-2:0], issue};
      rsp_valid <= flight_q[DEPTH-1];
      if (flight_q[DEPTH-1]) rsp_data <= dq_in;
    end
  end

  // R7: single-beat reads never overlap in the pipe
  a_r7_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flight_q) <= 1);
  // R7: the response strobe lasts one cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int BANK_W         = 2,
  parameter int ROW_W          = 11,
  parameter int COL_W          = 8,
  parameter int CAS_LAT        = 3,
  parameter int CLK_KHZ        = 125000,
  parameter int INIT_CYCLES    = CLK_KHZ / 10,
  parameter int REFRESH_CYCLES = CLK_KHZ * 125 / 8000,
  parameter int T_RCD          = 3,
  parameter int T_RP           = 3,
  parameter int T_RFC          = 9,
  parameter int T_MRD          = 2,
  parameter int T_WR           = 2,
  localparam int ADDR_W        = BANK_W + ROW_W + COL_W,
  localparam int BE_W          = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BE_W-1:0]   sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int AP_BIT  = 10;
  localparam int RD_HOLD = CAS_LAT + T_RP;
  localparam int WR_HOLD = T_WR + T_RP;
  localparam int WAIT_W  = $clog2(INIT_CYCLES + T_RFC + RD_HOLD + WR_HOLD + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  sd_cmd_e            cmd_q;
  ctrl_state_e        st_q;
  logic [WAIT_W-1:0]  wait_q;
  logic               wr_q;
  logic [COL_W-1:0]   col_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [BE_W-1:0]    be_q;
  logic               ref_pend;
  logic               ref_ack;
  logic               slot_free;
  logic               init_done;
  logic               rd_issue;
  logic [ROW_W-1:0]   col_word;
  logic [BANK_W-1:0]  req_bank;
  logic [ROW_W-1:0]   req_row;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke    = 1'b1;
  assign slot_free = (wait_q == '0);
  assign init_done = (st_q == ST_IDLE) || (st_q == ST_COL);
  assign req_ready = (st_q == ST_IDLE) && slot_free && !ref_pend;
  assign ref_ack   = (st_q == ST_IDLE) && slot_free && ref_pend;
  assign rd_issue  = (st_q == ST_COL) && slot_free && !wr_q;
  assign req_bank  = req_addr[ADDR_W-1 -: BANK_W];
  assign req_row   = req_addr[COL_W +: ROW_W];

  always_comb begin
    col_word         = ROW_W'(col_q);
    col_word[AP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_PWRUP;
      wait_q    <= WAIT_W'(INIT_CYCLES - 1);
      cmd_q     <= CMD_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dqm    <= '1;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      wr_q      <= 1'b0;
      col_q     <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
    end else begin
      cmd_q    <= CMD_NOP;
      sd_dq_oe <= 1'b0;
      if (!slot_free) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        unique case (st_q)
          ST_PWRUP: begin
            cmd_q           <= CMD_PRE;
            sd_addr         <= '0;
            sd_addr[AP_BIT] <= 1'b1;
            wait_q          <= WAIT_W'(T_RP - 1);
            st_q            <= ST_RF1;
          end
          ST_RF1: begin
            cmd_q  <= CMD_REF;
            wait_q <= WAIT_W'(T_RFC - 1);
            st_q   <= ST_RF2;
          end
          ST_RF2: begin
            cmd_q  <= CMD_REF;
            wait_q <= WAIT_W'(T_RFC - 1);
            st_q   <= ST_MODE;
          end
          ST_MODE: begin
            cmd_q   <= CMD_MRS;
            sd_ba   <= '0;
            sd_addr <= MODE_WORD;
            wait_q  <= WAIT_W'(T_MRD - 1);
            st_q    <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd_q  <= CMD_REF;
              wait_q <= WAIT_W'(T_RFC - 1);
            end else if (req_valid) begin
              cmd_q   <= CMD_ACT;
              sd_ba   <= req_bank;
              sd_addr <= req_row;
              wr_q    <= req_write;
              col_q   <= req_addr[COL_W-1:0];
              wdata_q <= req_wdata;
              be_q    <= req_be;
              wait_q  <= WAIT_W'(T_RCD - 1);
              st_q    <= ST_COL;
            end
          end
          ST_COL: begin
            sd_addr <= col_word;
            if (wr_q) begin
              cmd_q     <= CMD_WR;
              sd_dqm    <= ~be_q;
              sd_dq_out <= wdata_q;
              sd_dq_oe  <= 1'b1;
              wait_q    <= WAIT_W'(WR_HOLD - 1);
            end else begin
              cmd_q  <= CMD_RD;
              sd_dqm <= '0;
              wait_q <= WAIT_W'(RD_HOLD - 1);
            end
            st_q <= ST_IDLE;
          end
          default: st_q <= ST_PWRUP;
        endcase
      end
    end
  end

  sdram_refresh_timer #(.INTERVAL(REFRESH_CYCLES)) u_refresh (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (init_done),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  sdram_rd_pipe #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_rd_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (rd_issue),
    .dq_in    (sd_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  // R10: after an acceptance the port closes for the access
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R5: column commands always request auto-precharge
  a_r5_col_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_addr[AP_BIT]);
  // R8: the data bus is driven only alongside a write
  a_r8_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> cmd_q == CMD_WR);
  // R3: the mode load carries bank zero and the programmed word
  a_r3_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == CMD_MRS |-> (sd_addr == MODE_WORD && sd_ba == '0));
  // R1: clock enable never drops
  a_r1_cke_high: assert property (@(posedge clk) disable iff (!rst_n) sd_cke);
endmodule

// File: tb/sdram_ctrl_tb.sv
module sdram_ctrl_tb;
  import sdram_ctrl_pkg::*;

  localparam int CL    = 3;
  localparam int INIT  = 30;
  localparam int REFI  = 150;
  localparam int TRCD  = 3;
  localparam int TRP   = 3;
  localparam int TRFC  = 9;
  localparam int TMRD  = 2;
  localparam int TWR   = 2;
  localparam int SLACK = TRCD + CL + TRP + TWR + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [10:0] sd_addr;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_dq_out;
  logic        sd_dq_oe;
  logic [31:0] sd_dq_in = '0;

  always #4 clk = ~clk;

  sdram_ctrl #(.CAS_LAT(CL), .INIT_CYCLES(INIT), .REFRESH_CYCLES(REFI),
               .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .T_WR(TWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // behavioural memory model and command checker
  typedef struct { int due; logic [31:0] d; } ev_t;
  typedef struct { bit wr; logic [20:0] a; logic [31:0] d; logic [3:0] be; } rq_t;

  ev_t         dq_q[$];
  ev_t         exp_q[$];
  rq_t         acc_q[$];
  rq_t         cur;
  logic [31:0] mem[int];
  logic [10:0] open_row[4];
  bit          open_v[4];
  int          cyc = 0;
  int          last_cyc = 0;
  logic [3:0]  last_c = CMD_NOP;
  int          init_step = 0;
  int          last_ref = 0;
  int          ref_count = 0;

  function automatic logic [31:0] peek(int k);
    return mem.exists(k) ? mem[k] : (32'(k) ^ 32'hA5A5_0000);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] cmd;
      int gap, need, key;
      logic [31:0] old, nw;
      cyc++;
      sd_dq_in = '0;
      if (dq_q.size() > 0 && dq_q[0].due == cyc) begin
        sd_dq_in = dq_q[0].d;
        void'(dq_q.pop_front());
      end
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        chk(rsp_valid === 1'b1 && rsp_data === exp_q[0].d, "R7", "read return",
            {rsp_valid, rsp_data}, {1'b1, exp_q[0].d});
        void'(exp_q.pop_front());
      end else if (rsp_valid !== 1'b0) begin
        chk(1'b0, "R7", "response strobe at wrong time", rsp_valid, 0);
      end
      if (init_step < 4 && req_ready) chk(1'b0, "R1", "ready before init", 1, 0);
      if (sd_dq_oe && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != CMD_WR)
        chk(1'b0, "R8", "bus driven outside write", 1, 0);
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (cmd != CMD_NOP) begin
        gap = cyc - last_cyc;
        case (last_c)
          CMD_PRE: need = TRP;
          CMD_REF: need = TRFC;
          CMD_MRS: need = TMRD;
          CMD_RD:  need = CL + TRP;
          CMD_WR:  need = TWR + TRP;
          default: need = 0;
        endcase
        if (last_c == CMD_ACT)
          chk(gap == TRCD, "R5", "activate to column gap", gap, TRCD);
        else if (last_c == CMD_RD || last_c == CMD_WR)
          chk(gap >= need, "R6", "gap after column command", gap, need);
        else if (init_step > 0)
          chk(gap >= need, "R2", "command spacing", gap, need);
        if (init_step < 4) begin
          case (init_step)
            0: begin
              chk(cyc >= INIT, "R1", "first command after settling", cyc, INIT);
              chk(cmd == CMD_PRE && sd_addr[10], "R2", "precharge-all first",
                  {cmd, sd_addr}, {CMD_PRE, 11'h400});
            end
            1, 2: chk(cmd == CMD_REF, "R2", "init refresh", cmd, CMD_REF);
            default: begin
              chk(cmd == CMD_MRS, "R2", "mode load last", cmd, CMD_MRS);
              chk(sd_addr == 11'(CL << 4) && sd_ba == 2'd0, "R3", "mode word",
                  {sd_ba, sd_addr}, 11'(CL << 4));
              last_ref = cyc;
            end
          endcase
          init_step++;
        end else begin
          case (cmd)
            CMD_ACT: begin
              if (acc_q.size() == 0) begin
                chk(1'b0, "R10", "activate with no request", 0, 1);
              end else begin
                cur = acc_q.pop_front();
                chk(sd_ba == cur.a[20:19] && sd_addr == cur.a[18:8], "R4",
                    "activate bank/row", {sd_ba, sd_addr}, cur.a[20:8]);
                open_row[sd_ba] = sd_addr;
                open_v[sd_ba] = 1'b1;
              end
            end
            CMD_RD, CMD_WR: begin
              chk(sd_addr[10] == 1'b1, "R5", "auto-precharge flag", sd_addr[10], 1);
              chk(open_v[sd_ba] && sd_ba == cur.a[20:19] && sd_addr[7:0] == cur.a[7:0]
                  && ((cmd == CMD_WR) == cur.wr), "R4", "column command",
                  {cmd, sd_ba, sd_addr[7:0]}, {cur.wr ? CMD_WR : CMD_RD, cur.a[20:19], cur.a[7:0]});
              key = int'({sd_ba, open_row[sd_ba], sd_addr[7:0]});
              open_v[sd_ba] = 1'b0;
              if (cmd == CMD_WR) begin
                chk(sd_dq_oe && sd_dq_out == cur.d && sd_dqm == ~cur.be, "R8",
                    "write data and mask", {sd_dq_oe, sd_dqm, sd_dq_out},
                    {1'b1, ~cur.be, cur.d});
                old = peek(key);
                for (int b = 0; b < 4; b++)
                  nw[b*8 +: 8] = sd_dqm[b] ? old[b*8 +: 8] : sd_dq_out[b*8 +: 8];
                mem[key] = nw;
              end else begin
                chk(sd_dqm == 4'h0, "R8", "read mask", sd_dqm, 0);
                dq_q.push_back('{cyc + CL, peek(key)});
                exp_q.push_back('{cyc + CL + 1, peek(key)});
              end
            end
            CMD_REF: begin
              chk(cyc - last_ref <= REFI + SLACK, "R9", "refresh interval",
                  cyc - last_ref, REFI + SLACK);
              last_ref = cyc;
              ref_count++;
            end
            default: chk(1'b0, "R10", "unexpected command", cmd, CMD_NOP);
          endcase
        end
        last_cyc = cyc;
        last_c = cmd;
      end
    end
  end

  task automatic req(input bit wr, input logic [20:0] a, input logic [31:0] d,
                     input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    while (!req_ready) @(negedge clk);
    acc_q.push_back('{wr, a, d, be});
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", "ready low after accept", req_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sd_cke === 1'b1 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === CMD_NOP
        && req_ready === 1'b0 && sd_dq_oe === 1'b0 && rsp_valid === 1'b0,
        "R1", "reset state", {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_ready},
        {1'b1, CMD_NOP, 1'b0});
    rst_n = 1'b1;
    // writes across banks and address extremes
    req(1'b1, {2'd0, 11'd5, 8'd3},       32'h1111_2222, 4'hF);
    req(1'b1, {2'd3, 11'h7FF, 8'hFF},    32'hCAFE_F00D, 4'hF);
    req(1'b1, {2'd1, 11'd0, 8'd0},       32'h0BAD_BEEF, 4'hF);
    req(1'b1, {2'd2, 11'd100, 8'd77},    32'hAAAA_AAAA, 4'hF);
    req(1'b1, {2'd2, 11'd100, 8'd77},    32'h5555_5555, 4'b0101);
    // read back, including partial-mask merge and an unwritten location
    req(1'b0, {2'd0, 11'd5, 8'd3},       '0, 4'h0);
    req(1'b0, {2'd3, 11'h7FF, 8'hFF},    '0, 4'h0);
    req(1'b0, {2'd1, 11'd0, 8'd0},       '0, 4'h0);
    req(1'b0, {2'd2, 11'd100, 8'd77},    '0, 4'h0);
    req(1'b0, {2'd1, 11'd9, 8'd200},     '0, 4'h0);
    // idle long enough for several periodic refreshes (R9, R10)
    repeat (3 * REFI) @(negedge clk);
    // dense mixed traffic colliding with refresh
    for (int i = 0; i < 24; i++) begin
      req(1'b1, 21'(i * 4099), 32'h1000_0000 + 32'(i), 4'(i + 1));
      req(1'b0, 21'(i * 4099), '0, 4'h0);
    end
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0 && acc_q.size() == 0, "R7", "all reads returned",
        exp_q.size(), 0);
    chk(init_step == 4, "R2", "init sequence completed", init_step, 4);
    chk(ref_count >= 3, "R9", "periodic refreshes seen", ref_count, 3);
    finish_run();
  end
endmodule